// File: doc/BRIEF.md
# Stereo Sample Error Concealment with Zero-Crossing Mute

This block sits between the second-stage error decoder and the oversampling filter of a disc audio path. Each incoming stereo word carries a signed left sample, a signed right sample and one error flag per channel. A sample whose flag is clear passes unchanged. A flagged sample is replaced in one of two ways. If it ends a short error run and the sample after it is good, it becomes the mean of the last good sample and that next good sample. Otherwise it becomes a copy of the last good sample. The two channels are handled independently, each with its own run length and last-good value.

To see the sample after the one being emitted, the block holds one sample per channel in a lookahead stage. A sample is therefore emitted only when its successor has been accepted. A mute request does not cut the audio at once. Each channel goes silent at the first zero crossing of its concealed stream, and comes back at the first zero crossing after the request is withdrawn. A status output goes low while both channels are silent.

Both stream edges use a valid/ready handshake. The emitted word carries the error flags of the sample it replaces, so that later stages can see which samples were concealed.

Top module: `audio_conceal_mute`

## Requirements
- R1: After reset, `out_valid` is 0, `mute_n` is 1 and `in_ready` is 1.
- R2: The output for input sample k is produced only after input sample k+1 has been accepted. It appears on the output register at the clock edge that accepts sample k+1, so the very first sample alone never yields an output.
- R3: A sample whose error flag is 0 is emitted with its value unchanged.
- R4: Run length counts consecutive flagged samples, including the current one. A flagged sample is replaced by floor((last good + next)/2), computed in signed arithmetic, when three conditions all hold: the next sample of the same channel is unflagged, the sample's run length is at most RUN_MAX (default 2), and the next sample is that same unflagged one used in the mean.
- R5: A flagged sample is replaced by the channel's last unflagged input value (0 if there has been none since reset) in two cases: when the next sample is also flagged, or when its run length exceeds RUN_MAX.
- R6: Left and right keep separate run lengths and last-good values, so a flag on one channel never alters the other channel's output.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_left` and `out_right` hold their values.
- R8: With `mute_req`=1, an unmuted channel becomes muted at the first emitted sample that is a zero crossing of its concealed stream. A zero crossing is a sample whose sign bit differs from the previous concealed sample of that channel (taken as 0 after reset) or whose value is 0. That sample and every sample after it are emitted as 0.
- R9: With `mute_req`=0, a muted channel unmutes at the first emitted sample that is a zero crossing (same definition as R8). That sample carries its concealed value.
- R10: `mute_n` is 0 exactly while both channels are muted, and 1 otherwise.
- R11: `out_err_l`/`out_err_r` equal the input error flags of the sample being emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts the input word |
| in_left | input | SAMPLE_W | Left sample, two's complement |
| in_right | input | SAMPLE_W | Right sample, two's complement |
| in_err_l | input | 1 | Left sample flagged as uncorrectable |
| in_err_r | input | 1 | Right sample flagged as uncorrectable |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the output word |
| out_left | output | SAMPLE_W | Concealed and mute-gated left sample |
| out_right | output | SAMPLE_W | Concealed and mute-gated right sample |
| out_err_l | output | 1 | Left input flag of the emitted sample |
| out_err_r | output | 1 | Right input flag of the emitted sample |
| mute_req | input | 1 | Request silence at the next zero crossing |
| mute_n | output | 1 | Low while both channels are muted |

## Verification
Each emitted word belongs to the sample accepted one handshake earlier. It is registered at the edge that accepts the following sample and is visible from the next falling edge. Both the mute state change and `mute_n` take effect on that same edge. The driver therefore pushes the expected word for sample k into the scoreboard at the clock edge where sample k+1 is taken. The monitor compares values, flags and `mute_n` at the falling edge of each completed output handshake, so timing is counted per handshake rather than in fixed cycles. During stalls, held output values are compared from one falling edge to the next.

// File: rtl/acm_pkg.sv
`timescale 1ns/1ps
package acm_pkg;

  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    PICK_PASS = 2'd0,
    PICK_MEAN = 2'd1,
    PICK_HOLD = 2'd2
  } pick_e;

endpackage

// File: rtl/acm_lane.sv
`timescale 1ns/1ps
module acm_lane
  import acm_pkg::*;
#(
  parameter int W       = 16,
  parameter int RUN_MAX = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         primed,
  input  logic [W-1:0] nx_val,
  input  logic         nx_flag,
  output logic         cur_flag,
  output logic [W-1:0] conc,
  output pick_e        pick
);

  localparam int CW = $clog2(RUN_MAX + 2);
  localparam logic [CW-1:0] RUN_CAP = CW'(RUN_MAX + 1);
  localparam logic [CW-1:0] RUN_LIM = CW'(RUN_MAX);

  logic [W-1:0]  p_val;
  logic          p_flag;
  logic [CW-1:0] p_run;
  logic [W-1:0]  last_good;
  logic          short_run;

  function automatic logic [W-1:0] mean2(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [W:0] s;
    s = $signed({a[W-1], a}) + $signed({b[W-1], b});
    return s[W:1];
  endfunction

  function automatic logic [CW-1:0] run_next(input logic nflag, input logic chain,
                                             input logic [CW-1:0] run);
    if (!nflag)          return '0;
    else if (!chain)     return CW'(1);
    else if (run == RUN_CAP) return RUN_CAP;
    else                 return run + CW'(1);
  endfunction

  assign short_run = (p_run <= RUN_LIM);

  always_comb begin
    if (!p_flag)                    pick = PICK_PASS;
    else if (!nx_flag && short_run) pick = PICK_MEAN;
    else                            pick = PICK_HOLD;
  end

  always_comb begin
    unique case (pick)
      PICK_PASS: conc = p_val;
      PICK_MEAN: conc = mean2(last_good, nx_val);
      default:   conc = last_good;
    endcase
  end

  assign cur_flag = p_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_val     <= '0;
      p_flag    <= 1'b0;
      p_run     <= '0;
      last_good <= '0;
    end else if (load) begin
      if (primed && !p_flag) last_good <= p_val;
      p_val  <= nx_val;
      p_flag <= nx_flag;
      p_run  <= run_next(nx_flag, primed && p_flag, p_run);
    end
  end

endmodule

// File: rtl/acm_mute_gate.sv
`timescale 1ns/1ps
module acm_mute_gate #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         req,
  input  logic [W-1:0] conc,
  output logic [W-1:0] y,
  output logic         muted,
  output logic         zc
);

  logic [W-1:0] prev_c;
  logic         muted_nx;

  function automatic logic crossing(input logic [W-1:0] prev, input logic [W-1:0] cur);
    return (prev[W-1] ^ cur[W-1]) || (cur == '0);
  endfunction

  assign zc = crossing(prev_c, conc);

  always_comb begin
    if (muted) muted_nx = !(!req && zc);
    else       muted_nx = req && zc;
  end

  assign y = muted_nx ? '0 : conc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_c <= '0;
      muted  <= 1'b0;
    end else if (step) begin
      prev_c <= conc;
      muted  <= muted_nx;
    end
  end

endmodule

// File: rtl/audio_conceal_mute.sv
`timescale 1ns/1ps
module audio_conceal_mute
  import acm_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int RUN_MAX  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic                in_err_l,
  input  logic                in_err_r,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic                out_err_l,
  output logic                out_err_r,
  input  logic                mute_req,
  output logic                mute_n
);

  logic                have_p;
  logic                accept;
  logic                step;
  logic [SAMPLE_W-1:0] nx_v   [NUM_CH];
  logic                nx_f   [NUM_CH];
  logic [SAMPLE_W-1:0] conc_v [NUM_CH];
  logic [SAMPLE_W-1:0] gate_y [NUM_CH];
  logic                cur_f  [NUM_CH];
  pick_e               pick_w [NUM_CH];
  logic [NUM_CH-1:0]   ch_muted;
  logic [NUM_CH-1:0]   ch_zc;

  assign nx_v[0] = in_left;
  assign nx_v[1] = in_right;
  assign nx_f[0] = in_err_l;
  assign nx_f[1] = in_err_r;

  assign in_ready = !have_p || !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign step     = accept && have_p;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    acm_lane #(.W(SAMPLE_W), .RUN_MAX(RUN_MAX)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .primed   (have_p),
      .nx_val   (nx_v[ch]),
      .nx_flag  (nx_f[ch]),
      .cur_flag (cur_f[ch]),
      .conc     (conc_v[ch]),
      .pick     (pick_w[ch])
    );

    acm_mute_gate #(.W(SAMPLE_W)) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .req   (mute_req),
      .conc  (conc_v[ch]),
      .y     (gate_y[ch]),
      .muted (ch_muted[ch]),
      .zc    (ch_zc[ch])
    );
  end

  assign mute_n = !(&ch_muted);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_p    <= 1'b0;
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
      out_err_l <= 1'b0;
      out_err_r <= 1'b0;
    end else begin
      if (accept) have_p <= 1'b1;
      if (step) begin
        out_valid <= 1'b1;
        out_left  <= gate_y[0];
        out_right <= gate_y[1];
        out_err_l <= cur_f[0];
        out_err_r <= cur_f[1];
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/acm_checker.sv
`timescale 1ns/1ps
module acm_checker #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SAMPLE_W-1:0] out_left,
  input logic [SAMPLE_W-1:0] out_right,
  input logic                mute_req,
  input logic                mute_n,
  input logic [1:0]          muted,
  input logic [1:0]          zc
);

  // R7: a stalled output word stays put
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_left) && $stable(out_right));

  // R2: a new output word only follows an accepted input word
  p_out_needs_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R8: a muted channel emits silence
  p_mute_zero_l_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && muted[0] |-> out_left == '0);
  p_mute_zero_r_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && muted[1] |-> out_right == '0);

  // R8 / R9: state changes only at a zero crossing, in the requested direction
  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    p_mute_at_cross_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(muted[ch]) |-> $past(zc[ch] && mute_req));
    p_unmute_at_cross_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(muted[ch]) |-> $past(zc[ch] && !mute_req));
  end

  // R10: the status only drops in response to a request
  p_status_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute_n) |-> $past(mute_req));

endmodule

bind audio_conceal_mute acm_checker #(.SAMPLE_W(SAMPLE_W)) u_acm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_left  (out_left),
  .out_right (out_right),
  .mute_req  (mute_req),
  .mute_n    (mute_n),
  .muted     (ch_muted),
  .zc        (ch_zc)
);

// File: tb/test_audio_conceal_mute.sv
`timescale 1ns/1ps
module test_audio_conceal_mute;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_left = '0, in_right = '0;
  logic         in_err_l = 1'b0, in_err_r = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_left, out_right;
  logic         out_err_l, out_err_r;
  logic         mute_req = 1'b0;
  logic         mute_n;

  int checks = 0;
  int bad = 0;
  bit finished = 0;
  bit stall_mode = 0;
  int cyc = 0;
  string phase = "start";

  always #2 clk = ~clk;

  audio_conceal_mute #(.SAMPLE_W(W), .RUN_MAX(2)) i_audio_conceal_mute (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right),
    .in_err_l(in_err_l), .in_err_r(in_err_r),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_left(out_left), .out_right(out_right),
    .out_err_l(out_err_l), .out_err_r(out_err_r),
    .mute_req(mute_req), .mute_n(mute_n)
  );

  // scoreboard storage
  typedef struct packed {
    logic signed [31:0] l;
    logic signed [31:0] r;
    logic fl;
    logic fr;
    logic mn;
  } exp_t;
  exp_t  q[$];
  string qtag[$];

  // reference history
  int hv0[$], hv1[$];
  bit hf0[$], hf1[$];
  bit mt[2];
  int pc[2];

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] %s: got %0d expected %0d", req, phase, what, got, exp);
    end
  endtask

  function automatic int hval(int ch, int k);
    return (ch == 0) ? hv0[k] : hv1[k];
  endfunction
  function automatic bit hflg(int ch, int k);
    return (ch == 0) ? hf0[k] : hf1[k];
  endfunction

  // concealed value of sample k on channel ch, given sample k+1
  function automatic int conceal(int ch, int k, output string rule);
    int lg, run, s;
    if (!hflg(ch, k)) begin
      rule = "R3";
      return hval(ch, k);
    end
    lg = 0;
    for (int j = k - 1; j >= 0; j--) begin
      if (!hflg(ch, j)) begin lg = hval(ch, j); break; end
    end
    run = 0;
    for (int j = k; j >= 0; j--) begin
      if (hflg(ch, j)) run++; else break;
    end
    if (!hflg(ch, k + 1) && run <= 2) begin
      rule = "R4";
      s = lg + hval(ch, k + 1);
      return s >>> 1;
    end
    rule = "R5";
    return lg;
  endfunction

  function automatic int gate(int ch, int c, inout string rule);
    bit z;
    z = ((c < 0) != (pc[ch] < 0)) || (c == 0);
    if (!mt[ch] && mute_req && z) begin mt[ch] = 1; rule = {rule, "/R8"}; end
    else if (mt[ch] && !mute_req && z) begin mt[ch] = 0; rule = {rule, "/R9"}; end
    pc[ch] = c;
    return mt[ch] ? 0 : c;
  endfunction

  task automatic send(input int l, input int r, input bit fl, input bit fr);
    exp_t e;
    string rl, rr;
    int k, cl, cr;
    @(negedge clk);
    in_left  = W'(l);
    in_right = W'(r);
    in_err_l = fl;
    in_err_r = fr;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    hv0.push_back(l); hv1.push_back(r);
    hf0.push_back(fl); hf1.push_back(fr);
    k = hv0.size() - 2;
    if (k >= 0) begin
      cl = conceal(0, k, rl);
      cr = conceal(1, k, rr);
      e.l  = gate(0, cl, rl);
      e.r  = gate(1, cr, rr);
      e.fl = hf0[k];
      e.fr = hf1[k];
      e.mn = !(mt[0] && mt[1]);
      q.push_back(e);
      qtag.push_back({"L:", rl, " R:", rr});
    end
    #1 in_valid = 1'b0;
  endtask

  // downstream ready pattern, changed away from both edges
  always begin
    @(posedge clk);
    #1;
    cyc++;
    out_ready = stall_mode ? ((cyc % 3) == 0) : 1'b1;
  end

  // monitor
  bit           was_stall = 0;
  logic [W-1:0] held_l, held_r;
  always @(negedge clk) begin
    if (rst_n) begin
      if (was_stall && out_valid) begin
        check(out_left == held_l && out_right == held_r, "R7", "stalled word held",
              int'($signed(out_left)), int'($signed(held_l)));
      end
      was_stall = out_valid && !out_ready;
      held_l = out_left;
      held_r = out_right;
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(0, "R2", "output word with nothing expected", 1, 0);
        end else begin
          exp_t  e;
          string t;
          e = q.pop_front();
          t = qtag.pop_front();
          check(int'($signed(out_left)) == e.l, {t, " R6"}, "left value",
                int'($signed(out_left)), e.l);
          check(int'($signed(out_right)) == e.r, {t, " R6"}, "right value",
                int'($signed(out_right)), e.r);
          check(out_err_l == e.fl, "R11", "left flag", out_err_l, e.fl);
          check(out_err_r == e.fr, "R11", "right flag", out_err_r, e.fr);
          check(mute_n == e.mn, "R10", "mute status", mute_n, e.mn);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R1 reset";
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(mute_n == 1'b1, "R1", "mute_n after reset", mute_n, 1);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    phase = "R2 lookahead";
    send(100, -100, 0, 0);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R2", "no output from a lone sample", out_valid, 0);

    phase = "R3 clean pass";
    send(200, -200, 0, 0);
    send(-32768, 32767, 0, 0);
    send(5, -5, 0, 0);

    phase = "R4 isolated error";
    send(100, 7, 0, 0);
    send(999, 8, 1, 0);
    send(301, 9, 0, 0);
    send(-101, 10, 0, 0);
    send(1234, 11, 1, 0);
    send(0, 12, 0, 0);
    send(-32768, 13, 0, 0);
    send(77, 14, 1, 0);
    send(-32768, 15, 0, 0);

    phase = "R4/R5 run of two";
    send(40, 50, 0, 0);
    send(1, 1, 1, 1);
    send(2, 2, 1, 1);
    send(61, 71, 0, 0);

    phase = "R5 long run";
    send(-300, 300, 0, 0);
    send(9, 9, 1, 1);
    send(9, 9, 1, 1);
    send(9, 9, 1, 1);
    send(9, 9, 1, 1);
    send(500, -500, 0, 0);

    phase = "R6 independent channels";
    send(11, 21, 0, 1);
    send(12, 22, 1, 0);
    send(13, 23, 0, 1);
    send(14, 24, 0, 1);
    send(15, 25, 0, 1);
    send(16, 26, 0, 0);

    phase = "R7 backpressure";
    stall_mode = 1;
    for (int i = 0; i < 12; i++) begin
      send(i * 37 - 200, 200 - i * 41, (i % 4) == 2, (i % 5) == 3);
    end
    stall_mode = 0;

    phase = "R8/R10 mute at crossing";
    send(1000, 1000, 0, 0);
    mute_req = 1'b1;
    send(2000, 2000, 0, 0);
    send(3000, 3000, 0, 0);
    send(-500, 4000, 0, 0);
    send(-600, -100, 0, 0);
    send(-700, -200, 0, 0);
    send(800, 300, 0, 0);

    phase = "R9 unmute at crossing";
    mute_req = 1'b0;
    send(900, 400, 0, 0);
    send(-900, 500, 0, 0);
    send(-800, 600, 0, 0);
    send(-700, -600, 0, 0);
    send(10, 10, 0, 0);

    phase = "R8 mute with flagged zero";
    mute_req = 1'b1;
    send(100, 100, 0, 0);
    send(55, 55, 1, 1);
    send(0, 0, 0, 0);
    send(300, 300, 0, 0);
    mute_req = 1'b0;
    send(-1, -1, 0, 0);
    send(4, 4, 0, 0);

    phase = "drain";
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R2", "last sample waits in lookahead", out_valid, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule